// File: doc/BRIEF.md
# Parallel-in serial-out word FIFO

This block buffers 16-bit words that arrive on a parallel port and sends them out one bit at a time on a single serial line. A word is written by an active-low strobe. The strobe falling opens the write cycle. The strobe rising captures the data word and advances the write pointer. The read side is a shift register. It takes the oldest stored word as soon as it is idle and a word is available. After that, each serial clock enable consumes one bit.

The bit order is chosen per word. The order input is sampled when a word moves into the shifter, so a word is never sent in two orders. When a word has sent its last bit and another word is waiting, the next word takes its place on the same edge, with no idle cycle in between. The shifter counts as one storage slot, so the block holds up to DEPTH words in memory plus one word in the shifter.

All signals are synchronous to one system clock. The write strobe and the serial clock enable are sampled as levels on that clock.

Top module: `serial_out_fifo`

## Requirements
- R1: After reset, both pointers are at the first location and nothing is stored: `sdo_live` is 0 and `sdo` is 0. A reset during operation discards every stored word, and the next written word is the next word sent.
- R2: A write is accepted when `wr_n` is seen low after being high and then seen high again. The data captured is the `wr_data` value present in the cycle where `wr_n` is first seen high again.
- R3: Storage holds DEPTH words in memory plus one in the shifter. A write whose strobe falls while the memory holds DEPTH words is discarded entirely, even if the strobe rises after space has been freed.
- R4: While no word is in the shifter, `sclk_en` pulses have no effect. `sdo` stays 0, and a word written later is sent complete from its first bit.
- R5: With `msb_first` = 0 at load, bit 0 is sent first and bit 15 last.
- R6: With `msb_first` = 1 at load, bit 15 is sent first and bit 0 last.
- R7: `msb_first` is sampled only when a word moves into the shifter. Changing it during a word does not alter that word's order.
- R8: When `sdo_live` is 1, `sdo` shows the current bit, and each cycle with `sclk_en` = 1 moves to the next bit. After the 16th bit, a waiting word is presented in the following cycle with no gap.
- R9: Words are sent in the order they were written.
- R10: A write accepted in the same cycle that a word moves into the shifter leaves the stored count unchanged, and neither word is lost.
- R11: Holding `wr_n` low for several cycles stores exactly one word per low-to-high cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_n | input | 1 | Active-low write strobe, sampled each clock |
| wr_data | input | 16 | Parallel write word |
| sclk_en | input | 1 | Serial clock enable; one bit consumed per high cycle |
| msb_first | input | 1 | Bit order for the next loaded word: 1 = bit 15 first, 0 = bit 0 first |
| sdo | output | 1 | Serial data out; 0 when no word is in the shifter |
| sdo_live | output | 1 | A word is present in the shifter and `sdo` is valid |

## Verification
The hardest case to reach is a write that completes on the same clock edge as the shifter reload. Here the count must rise and fall at once and stay unchanged. The stimulus reaches it by timing the strobe from inside the serial read loop. The strobe falls one bit before the end of a word and rises on the 16th bit's enable, while one word is waiting in memory. The bench then drains the FIFO and confirms that both the waiting word and the new word come out, and nothing more. The full boundary is reached by writing DEPTH+1 words, because the first word is pulled straight into the shifter.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

  localparam int WORD_W    = 16;
  localparam int BIT_IDX_W = $clog2(WORD_W);

  typedef logic [WORD_W-1:0] word_t;

  // write strobe phase
  typedef enum logic [1:0] {
    WS_HIGH    = 2'd0,
    WS_ARMED   = 2'd1,
    WS_BLOCKED = 2'd2
  } wstb_e;

  // bit currently presented on the serial line
  function automatic logic head_bit(input word_t w, input logic msb);
    return msb ? w[WORD_W-1] : w[0];
  endfunction

  // word after one bit has been consumed
  function automatic word_t shift_word(input word_t w, input logic msb);
    return msb ? {w[WORD_W-2:0], 1'b0} : {1'b0, w[WORD_W-1:1]};
  endfunction

endpackage

// File: rtl/sfifo_wr_ctrl.sv
module sfifo_wr_ctrl
  import sfifo_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_n,
  input  logic          full,
  output logic          wr_commit,
  output logic [AW-1:0] wptr
);

  logic  wr_n_q;
  wstb_e phase;
  logic  stb_fall;
  logic  stb_rise;

  assign stb_fall  = wr_n_q & ~wr_n;
  assign stb_rise  = ~wr_n_q & wr_n;
  assign wr_commit = stb_rise & (phase == WS_ARMED);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_n_q <= 1'b1;
      phase  <= WS_HIGH;
      wptr   <= '0;
    end else begin
      wr_n_q <= wr_n;
      if (stb_fall)
        phase <= full ? WS_BLOCKED : WS_ARMED;
      else if (stb_rise)
        phase <= WS_HIGH;
      if (wr_commit)
        wptr <= wptr + 1'b1;
    end
  end

  // R11
  single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit);

  // R2
  commit_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> (wr_n && $past(!wr_n)));

endmodule

// File: rtl/sfifo_store.sv
module sfifo_store
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  word_t         wdata,
  input  logic [AW-1:0] raddr,
  output word_t         rdata
);

  word_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/sfifo_occ.sv
module sfifo_occ #(
  parameter int DEPTH = 256,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] occ,
  output logic          full,
  output logic          empty
);

  function automatic logic [CW-1:0] occ_step(input logic [CW-1:0] c,
                                             input logic up, input logic dn);
    case ({up, dn})
      2'b10:   return c + 1'b1;
      2'b01:   return c - 1'b1;
      default: return c;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) occ <= '0;
    else        occ <= occ_step(occ, inc, dec);
  end

  assign full  = (occ == CW'(DEPTH));
  assign empty = (occ == '0);

  // R10
  both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec) |=> (occ == $past(occ)));

  // R3
  inc_not_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> (occ < CW'(DEPTH)));

endmodule

// File: rtl/sfifo_shifter.sv
module sfifo_shifter
  import sfifo_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sclk_en,
  input  logic  msb_first,
  input  logic  avail,
  input  word_t word_in,
  output logic  load,
  output logic  sdo,
  output logic  live
);

  word_t                sh_word;
  logic                 dir_q;
  logic [BIT_IDX_W-1:0] bit_idx;
  logic                 last_bit;
  logic                 take;

  assign last_bit = (bit_idx == BIT_IDX_W'(WORD_W - 1));
  assign take     = live & sclk_en;
  assign load     = avail & (~live | (take & last_bit));
  assign sdo      = live & head_bit(sh_word, dir_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_word <= '0;
      dir_q   <= 1'b0;
      bit_idx <= '0;
      live    <= 1'b0;
    end else if (load) begin
      sh_word <= word_in;
      dir_q   <= msb_first;
      bit_idx <= '0;
      live    <= 1'b1;
    end else if (take) begin
      sh_word <= shift_word(sh_word, dir_q);
      bit_idx <= bit_idx + 1'b1;
      if (last_bit)
        live <= 1'b0;
    end
  end

  // R7
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !load) |=> $stable(dir_q));

  // R8
  no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && last_bit && avail) |=> (live && bit_idx == '0));

  // R4
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!live && !avail) |=> !live);

endmodule

// File: rtl/serial_out_fifo.sv
module serial_out_fifo
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              sclk_en,
  input  logic              msb_first,
  output logic              sdo,
  output logic              sdo_live
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic          wr_commit;
  logic [AW-1:0] wptr;
  logic [AW-1:0] rptr;
  logic [CW-1:0] occ;
  logic          full;
  logic          empty;
  logic          ld;
  word_t         rd_word;

  sfifo_wr_ctrl #(.AW(AW)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .full(full),
    .wr_commit(wr_commit), .wptr(wptr)
  );

  sfifo_store #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .we(wr_commit), .waddr(wptr), .wdata(wr_data),
    .raddr(rptr), .rdata(rd_word)
  );

  sfifo_occ #(.DEPTH(DEPTH), .CW(CW)) u_occ (
    .clk(clk), .rst_n(rst_n), .inc(wr_commit), .dec(ld),
    .occ(occ), .full(full), .empty(empty)
  );

  sfifo_shifter u_sh (
    .clk(clk), .rst_n(rst_n), .sclk_en(sclk_en), .msb_first(msb_first),
    .avail(~empty), .word_in(rd_word), .load(ld), .sdo(sdo), .live(sdo_live)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)  rptr <= '0;
    else if (ld) rptr <= rptr + 1'b1;
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |-> (occ != '0));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_live |-> !sdo);

endmodule

// File: tb/serial_out_fifo_bench.sv
module serial_out_fifo_bench;

  localparam int DEPTH = 256;

  typedef struct packed {
    logic [15:0] d;
    logic        msb;
  } vec_t;

  // R5 R6 R9: words and their bit order, sent back to back
  localparam vec_t TBL [8] = '{
    '{16'hA5C3, 1'b1}, '{16'h0001, 1'b0}, '{16'h8000, 1'b1}, '{16'h8000, 1'b0},
    '{16'h1234, 1'b0}, '{16'hFFFE, 1'b1}, '{16'h7F00, 1'b0}, '{16'h0F0F, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_n = 1'b1;
  logic [15:0] wr_data = '0;
  logic        sclk_en = 1'b0;
  logic        msb_first = 1'b0;
  logic        sdo;
  logic        sdo_live;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  serial_out_fifo #(.DEPTH(DEPTH)) u_serial_out_fifo (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .wr_data(wr_data),
    .sclk_en(sclk_en), .msb_first(msb_first), .sdo(sdo), .sdo_live(sdo_live)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // R2: strobe low, data changed, strobe high, one idle cycle
  task automatic write_word(input logic [15:0] d);
    wr_n = 1'b0;
    wr_data = ~d;
    @(negedge clk);
    wr_n = 1'b1;
    wr_data = d;
    @(negedge clk);
    @(negedge clk);
  endtask

  // Reads one word; flips msb_first mid-word (R7), sets next order before the
  // last edge, and optionally completes a write on the 16th edge (R10).
  task automatic read_word(input logic [15:0] exp, input logic dir,
                           input logic next_dir, input bit do_wr,
                           input logic [15:0] wdat, input string req);
    logic [15:0] got = '0;
    chk(sdo_live === 1'b1, {req, " live"}, 32'(sdo_live), 1);
    for (int i = 0; i < 16; i++) begin
      got[dir ? 15 - i : i] = sdo;
      sclk_en = 1'b1;
      if (i == 7) msb_first = ~dir;
      if (i == 14 && do_wr) wr_n = 1'b0;
      if (i == 15) begin
        msb_first = next_dir;
        if (do_wr) begin
          wr_n = 1'b1;
          wr_data = wdat;
        end
      end
      @(negedge clk);
    end
    sclk_en = 1'b0;
    chk(got === exp, req, 32'(got), 32'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(sdo_live === 1'b0, "R1 live after reset", 32'(sdo_live), 0);
    chk(sdo === 1'b0, "R1 sdo after reset", 32'(sdo), 0);

    // table walk: R2 R5 R6 R7 R8 R9
    msb_first = TBL[0].msb;
    foreach (TBL[i]) write_word(TBL[i].d);
    foreach (TBL[i]) begin
      logic nd;
      nd = (i < 7) ? TBL[i + 1].msb : 1'b0;
      read_word(TBL[i].d, TBL[i].msb, nd, 1'b0, '0,
                TBL[i].msb ? "R6 R9 R8 msb word" : "R5 R9 R8 lsb word");
    end
    chk(sdo_live === 1'b0, "R9 drained", 32'(sdo_live), 0);

    // R4 serial clocks while empty
    msb_first = 1'b1;
    for (int k = 0; k < 5; k++) begin
      sclk_en = 1'b1;
      @(negedge clk);
      chk(sdo === 1'b0 && sdo_live === 1'b0, "R4 idle sclk", {sdo_live, sdo}, 0);
    end
    sclk_en = 1'b0;
    write_word(16'hC001);
    read_word(16'hC001, 1'b1, 1'b0, 1'b0, '0, "R4 full word after idle clocks");

    // R11 strobe held low, data changing, one word stored
    wr_n = 1'b0;
    for (int k = 0; k < 5; k++) begin
      wr_data = 16'(k * 16'h1111);
      @(negedge clk);
    end
    wr_n = 1'b1;
    wr_data = 16'h3C5A;
    @(negedge clk);
    @(negedge clk);
    read_word(16'h3C5A, 1'b0, 1'b0, 1'b0, '0, "R11 R2 data at rise");
    @(negedge clk);
    chk(sdo_live === 1'b0, "R11 only one word", 32'(sdo_live), 0);

    // R10 write completes on the reload edge
    write_word(16'hAAAA);
    write_word(16'h5555);
    read_word(16'hAAAA, 1'b0, 1'b0, 1'b1, 16'h0F1E, "R10 first");
    read_word(16'h5555, 1'b0, 1'b0, 1'b0, '0, "R10 waiting word");
    read_word(16'h0F1E, 1'b0, 1'b0, 1'b0, '0, "R10 same-edge write");
    chk(sdo_live === 1'b0, "R10 nothing extra", 32'(sdo_live), 0);

    // R3 fill to DEPTH+1, extra writes discarded
    msb_first = 1'b0;
    for (int k = 0; k <= DEPTH; k++) write_word(16'(k * 7 + 3));
    write_word(16'hDEAD);
    write_word(16'hBEEF);
    for (int k = 0; k <= DEPTH; k++)
      read_word(16'(k * 7 + 3), 1'b0, 1'b0, 1'b0, '0, "R3 stored word");
    @(negedge clk);
    chk(sdo_live === 1'b0, "R3 overflow discarded", 32'(sdo_live), 0);

    // R1 reset during operation discards stored words
    write_word(16'h1111);
    write_word(16'h2222);
    write_word(16'h3333);
    do_reset();
    chk(sdo_live === 1'b0, "R1 live after mid reset", 32'(sdo_live), 0);
    chk(sdo === 1'b0, "R1 sdo after mid reset", 32'(sdo), 0);
    msb_first = 1'b1;
    write_word(16'h6789);
    read_word(16'h6789, 1'b1, 1'b0, 1'b0, '0, "R1 first word after reset");
    @(negedge clk);
    chk(sdo_live === 1'b0, "R1 old words gone", 32'(sdo_live), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule